// File: doc/BRIEF.md
# Reset-Time Memory Configuration Loader

This block runs once after every reset and settles how the external memory interface will be timed. First it probes the bus. It drives every data line high, and then it pulls a fixed set of lines low one after another while it watches a single configuration input. The board ties that input to one of the probed lines. When the input drops in the step that pulls a given line low, the block takes the preset configuration that belongs to that line, and no further bus activity follows.

When no preset is caught, the block asks the memory sequencer for 36 read cycles at fixed addresses near the top of memory. The sequencer runs those reads with its slowest default timing. The data returned on the bus is discarded. For each read, the block samples the configuration input once. That sample carries the complement of one configuration bit. The bits build the 36-bit word from the least significant end, and the word is inverted when all 36 are in.

After loading, the word is frozen until the next reset. A valid flag marks this point. Until the flag is raised, ordinary memory requests are refused.

The read-request channel follows valid/ready rules. A request, with its address, stays asserted and unchanged until the sequencer accepts it. Only one read is in flight at a time. The next request appears only after the sequencer signals that the accepted read has completed.

Top module: `memcfg_loader`

## Requirements
- R1: While reset is held, `cfg_valid`, `scan_en`, `rd_valid` and `mem_gnt` are all low.
- R2: After reset the block drives `scan_en` high with all 32 lines of `scan_data` at 1 for STEP_CYCLES (default 4) clocks. It then clears lines one step at a time, in the order 0, 1, 2, …, 11, 31, each step lasting STEP_CYCLES clocks. Lines that are cleared stay at 0. Lines 12 to 30 stay at 1.
- R3: Suppose `cfg_pin` is high in the last clock of the all-high phase and low in the last clock of step k, where k is 0 to 12. Then preset k is loaded, the scan stops, no read is requested, and `cfg_valid` rises. Preset k for k < 12 is encoded as follows:
  - bits [11:0] hold six 2-bit timing-state codes, each equal to k/4;
  - bits [16:12], [21:17], [26:22] and [31:27] hold k+1, k+2, k+3 and k+4;
  - bit 32 holds k mod 2;
  - bit 33 holds 1;
  - bits [35:34] hold k mod 4.
- R4: Preset 12, which belongs to line 31, is the slowest configuration. Every timing-state code is 3, every strobe field is 31, and bits 32, 33 and [35:34] are 1, 1 and 3.
- R5: If `cfg_pin` is low in the last clock of the all-high phase, no preset is taken even if the pin later drops with a line. The full scan runs and the 36 reads follow. `scan_en` and `rd_valid` are never high together.
- R6: When no preset is taken, exactly 36 reads are requested. The first is at 0x7FFFFF6C. Read i, for i of 1 or more, is at 0x7FFFFF70 + 4·(i−1), so the last read is at 0x7FFFFFF8.
- R7: `rd_valid` and `rd_addr` hold steady until `rd_ready` is sampled high. After acceptance, no new request appears until `rd_done` pulses.
- R8: In the clock where `rd_done` is high for read i, the block samples `cfg_pin` into bit i, starting from bit 0. The loaded word is the bitwise complement of the 36 samples.
- R9: `cfg_valid` rises only once loading is complete. From then until reset, `cfg_word` stays unchanged whatever `cfg_pin` does, and `scan_en` and `rd_valid` stay low.
- R10: `mem_gnt` equals `mem_req` while `cfg_valid` is high and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pin | input | 1 | Configuration sense input |
| scan_en | output | 1 | Block owns the data lines for the probe |
| scan_data | output | 32 | Probe pattern on the data lines |
| rd_valid | output | 1 | Configuration read requested |
| rd_ready | input | 1 | Sequencer accepts the request |
| rd_addr | output | 32 | Byte address of the requested read |
| rd_done | input | 1 | One-clock pulse: accepted read finished |
| mem_req | input | 1 | Ordinary memory request |
| mem_gnt | output | 1 | Ordinary request allowed |
| cfg_valid | output | 1 | Configuration word loaded |
| cfg_word | output | 36 | Loaded configuration word |

## Verification
The overlap that matters is an ordinary memory request arriving in the same clock that loading finishes. This happens either with the last `rd_done` pulse or with the step where the preset is caught. The bench holds `mem_req` high through every load, so the request is present in exactly that clock. It counts any grant seen before `cfg_valid` as a failure. It then requires the grant to be present in the first clock that `cfg_valid` is high. Back-pressure on the read channel gets a similar treatment: the bench withholds `rd_ready` for several clocks and checks that the address does not move during the wait.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;
  localparam int CFG_BITS     = 36;
  localparam int N_PRESETS    = 13;
  localparam int LOW_RUN      = 12;
  localparam int TOP_LINE     = 31;
  localparam int PRESET_IDX_W = $clog2(N_PRESETS);

  typedef logic [CFG_BITS-1:0] cfg_word_t;

  typedef enum logic [1:0] {SC_IDLE, SC_HIGH, SC_STEP, SC_DONE} scan_state_e;
  typedef enum logic [1:0] {RD_IDLE, RD_REQ, RD_WAIT, RD_DONE} rd_state_e;

  // Bus line cleared in a given probe step: a contiguous low run, then the top line.
  function automatic int line_of_step(int step);
    return (step < LOW_RUN) ? step : TOP_LINE;
  endfunction

  // Preset table entry k; the final entry is the slowest timing.
  function automatic cfg_word_t preset_word(int k);
    cfg_word_t w;
    w = '0;
    if (k == N_PRESETS - 1) begin
      for (int j = 0; j < 6; j++) w[2*j +: 2] = 2'd3;
      for (int j = 0; j < 4; j++) w[12 + 5*j +: 5] = 5'd31;
      w[32]    = 1'b1;
      w[33]    = 1'b1;
      w[35:34] = 2'd3;
    end else begin
      for (int j = 0; j < 6; j++) w[2*j +: 2] = 2'(k / 4);
      for (int j = 0; j < 4; j++) w[12 + 5*j +: 5] = 5'(k + 1 + j);
      w[32]    = 1'(k % 2);
      w[33]    = 1'b1;
      w[35:34] = 2'(k % 4);
    end
    return w;
  endfunction
endpackage

// File: rtl/memcfg_scan_walker.sv
module memcfg_scan_walker
  import memcfg_pkg::*;
#(
  parameter int STEP_CYCLES = 4,
  parameter int BUS_W       = 32,
  parameter int N_STEPS     = N_PRESETS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_pin,
  output logic                    scan_en,
  output logic [BUS_W-1:0]        scan_data,
  output logic                    scan_done,
  output logic                    preset_hit,
  output logic [PRESET_IDX_W-1:0] preset_idx
);
  localparam int CNT_W  = $clog2(STEP_CYCLES + 1);
  localparam int STEP_W = $clog2(N_STEPS + 1);
  localparam int LINE_W = $clog2(BUS_W);
  localparam logic [CNT_W-1:0]  CNT_LAST   = CNT_W'(STEP_CYCLES - 1);
  localparam logic [STEP_W-1:0] STEP_LAST  = STEP_W'(N_STEPS - 1);
  localparam logic [LINE_W-1:0] FIRST_LINE = LINE_W'(line_of_step(0));

  scan_state_e       state;
  logic [CNT_W-1:0]  cnt;
  logic [STEP_W-1:0] step;
  logic [BUS_W-1:0]  low_mask;
  logic              pre_low;
  logic [LINE_W-1:0] next_line;

  always_comb begin
    next_line = LINE_W'(line_of_step(int'(step) + 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SC_IDLE;
      cnt        <= '0;
      step       <= '0;
      low_mask   <= '0;
      pre_low    <= 1'b0;
      preset_hit <= 1'b0;
      preset_idx <= '0;
    end else begin
      case (state)
        SC_IDLE: begin
          state    <= SC_HIGH;
          cnt      <= '0;
          low_mask <= '0;
        end
        SC_HIGH: begin
          if (cnt == CNT_LAST) begin
            pre_low              <= ~cfg_pin;
            state                <= SC_STEP;
            step                 <= '0;
            cnt                  <= '0;
            low_mask[FIRST_LINE] <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SC_STEP: begin
          if (cnt == CNT_LAST) begin
            cnt <= '0;
            if (!cfg_pin && !pre_low) begin
              preset_hit <= 1'b1;
              preset_idx <= PRESET_IDX_W'(step);
              state      <= SC_DONE;
            end else if (step == STEP_LAST) begin
              state <= SC_DONE;
            end else begin
              step                <= step + 1'b1;
              low_mask[next_line] <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign scan_en   = (state == SC_HIGH) || (state == SC_STEP);
  assign scan_data = ~low_mask;
  assign scan_done = (state == SC_DONE);
endmodule

// File: rtl/memcfg_read_shifter.sv
module memcfg_read_shifter
  import memcfg_pkg::*;
#(
  parameter int          N_READS    = CFG_BITS,
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] FIRST_ADDR = 32'h7FFF_FF6C,
  parameter logic [31:0] RUN_BASE   = 32'h7FFF_FF70
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               cfg_pin,
  input  logic               rd_ready,
  input  logic               rd_done,
  output logic               rd_valid,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic [N_READS-1:0] samples,
  output logic               done
);
  localparam int IDX_W = $clog2(N_READS + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_READS - 1);

  rd_state_e        state;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= RD_IDLE;
      idx     <= '0;
      samples <= '0;
    end else begin
      case (state)
        RD_IDLE: if (start) begin
          state <= RD_REQ;
          idx   <= '0;
        end
        RD_REQ: if (rd_ready) state <= RD_WAIT;
        RD_WAIT: if (rd_done) begin
          samples[idx] <= cfg_pin;
          if (idx == IDX_LAST) begin
            state <= RD_DONE;
          end else begin
            idx   <= idx + 1'b1;
            state <= RD_REQ;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (idx == '0) rd_addr = ADDR_W'(FIRST_ADDR);
    else           rd_addr = ADDR_W'(RUN_BASE) + (ADDR_W'(idx - 1'b1) << 2);
  end

  assign rd_valid = (state == RD_REQ);
  assign done     = (state == RD_DONE);
endmodule

// File: rtl/memcfg_preset_table.sv
module memcfg_preset_table
  import memcfg_pkg::*;
(
  input  logic [PRESET_IDX_W-1:0] idx,
  output cfg_word_t               word
);
  cfg_word_t table_w [N_PRESETS];

  for (genvar k = 0; k < N_PRESETS; k++) begin : g_preset
    assign table_w[k] = preset_word(k);
  end

  always_comb begin
    word = table_w[N_PRESETS-1];
    for (int k = 0; k < N_PRESETS; k++) begin
      if (idx == PRESET_IDX_W'(k)) word = table_w[k];
    end
  end
endmodule

// File: rtl/memcfg_loader.sv
module memcfg_loader
  import memcfg_pkg::*;
#(
  parameter int STEP_CYCLES = 4,
  parameter int BUS_W       = 32,
  parameter int ADDR_W      = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_pin,
  output logic                scan_en,
  output logic [BUS_W-1:0]    scan_data,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [ADDR_W-1:0]   rd_addr,
  input  logic                rd_done,
  input  logic                mem_req,
  output logic                mem_gnt,
  output logic                cfg_valid,
  output logic [CFG_BITS-1:0] cfg_word
);
  logic                    scan_done;
  logic                    preset_hit;
  logic [PRESET_IDX_W-1:0] preset_idx;
  cfg_word_t               preset_w;
  logic [CFG_BITS-1:0]     samples;
  logic                    reads_done;

  memcfg_scan_walker #(
    .STEP_CYCLES(STEP_CYCLES),
    .BUS_W      (BUS_W),
    .N_STEPS    (N_PRESETS)
  ) walker_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_pin   (cfg_pin),
    .scan_en   (scan_en),
    .scan_data (scan_data),
    .scan_done (scan_done),
    .preset_hit(preset_hit),
    .preset_idx(preset_idx)
  );

  memcfg_preset_table table_i (
    .idx (preset_idx),
    .word(preset_w)
  );

  memcfg_read_shifter #(
    .N_READS(CFG_BITS),
    .ADDR_W (ADDR_W)
  ) reader_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (scan_done && !preset_hit),
    .cfg_pin (cfg_pin),
    .rd_ready(rd_ready),
    .rd_done (rd_done),
    .rd_valid(rd_valid),
    .rd_addr (rd_addr),
    .samples (samples),
    .done    (reads_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_valid <= 1'b0;
      cfg_word  <= '0;
    end else if (!cfg_valid) begin
      if (scan_done && preset_hit) begin
        cfg_word  <= preset_w;
        cfg_valid <= 1'b1;
      end else if (reads_done) begin
        cfg_word  <= ~samples;
        cfg_valid <= 1'b1;
      end
    end
  end

  assign mem_gnt = mem_req && cfg_valid;
endmodule

// File: rtl/memcfg_loader_chk.sv
module memcfg_loader_chk #(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 32,
  parameter int CW     = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scan_en,
  input logic [BUS_W-1:0]  scan_data,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              mem_gnt,
  input logic              cfg_valid,
  input logic [CW-1:0]     cfg_word
);
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  assert_gnt_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_gnt |-> cfg_valid);

  assert_word_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> cfg_valid && $stable(cfg_word));

  assert_quiet_after_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> !scan_en && !rd_valid);

  assert_reads_after_scan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> !rd_valid);

  assert_scan_monotone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en && $past(scan_en) |->
      ($countones(scan_data) == $countones($past(scan_data))) ||
      ($countones(scan_data) + 1 == $countones($past(scan_data))));
endmodule

bind memcfg_loader memcfg_loader_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .scan_en  (scan_en),
  .scan_data(scan_data),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_addr  (rd_addr),
  .mem_gnt  (mem_gnt),
  .cfg_valid(cfg_valid),
  .cfg_word (cfg_word)
);

// File: tb/memcfg_loader_tb_top.sv
`timescale 1ns/1ps
module memcfg_loader_tb_top;
  localparam int S = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_pin;
  logic        scan_en;
  logic [31:0] scan_data;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [31:0] rd_addr;
  logic        rd_done = 1'b0;
  logic        mem_req = 1'b1;
  logic        mem_gnt;
  logic        cfg_valid;
  logic [35:0] cfg_word;

  int checks = 0;
  int fails  = 0;

  // stimulus model
  int          mode = 0;      // 0 tied, 1 held low, 2 never low, 3 low in high phase then tied to 3
  int          tie_line = 0;
  logic [35:0] ext_word = '0;
  int          bp = 0;
  logic        ext_drv = 1'b0;
  logic        force_en = 1'b0;
  logic        force_val = 1'b1;
  int          rd_idx = 0;
  bit          word_seen = 0;
  int          steps_seen = 0;

  logic [31:0] exp_addr_q[$];
  logic [35:0] exp_word_q[$];

  always #4 clk = ~clk;

  always_comb begin
    if (force_en)       cfg_pin = force_val;
    else if (mode == 0) cfg_pin = scan_en ? scan_data[tie_line] : 1'b1;
    else if (mode == 1) cfg_pin = scan_en ? 1'b0 : ext_drv;
    else if (mode == 2) cfg_pin = 1'b1;
    else                cfg_pin = scan_en ? ((&scan_data) ? 1'b0 : scan_data[3]) : ext_drv;
  end

  memcfg_loader dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_pin(cfg_pin), .scan_en(scan_en),
    .scan_data(scan_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_done(rd_done), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .cfg_valid(cfg_valid), .cfg_word(cfg_word)
  );

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] exp_preset(int k);
    logic [35:0] w = '0;
    if (k == 12) begin
      for (int j = 0; j < 6; j++) w[2*j +: 2] = 2'd3;
      w[16:12] = 5'd31; w[21:17] = 5'd31; w[26:22] = 5'd31; w[31:27] = 5'd31;
      w[32] = 1'b1; w[33] = 1'b1; w[35:34] = 2'd3;
    end else begin
      for (int j = 0; j < 6; j++) w[2*j +: 2] = 2'(k / 4);
      w[16:12] = 5'(k + 1); w[21:17] = 5'(k + 2);
      w[26:22] = 5'(k + 3); w[31:27] = 5'(k + 4);
      w[32] = 1'(k % 2); w[33] = 1'b1; w[35:34] = 2'(k % 4);
    end
    return w;
  endfunction

  function automatic logic [31:0] exp_pattern(int n);
    logic [31:0] m = '0;
    for (int s = 0; s <= n; s++) m[(s < 12) ? s : 31] = 1'b1;
    return ~m;
  endfunction

  // scan monitor: order and duration of the probe (R2)
  initial begin
    logic [31:0] prev = '0;
    bit was_en = 0;
    int hold = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        was_en = 0; steps_seen = 0;
      end else if (scan_en && !was_en) begin
        chk(scan_data == 32'hFFFF_FFFF, "R2 all-high phase", scan_data, 32'hFFFF_FFFF);
        prev = scan_data; hold = 1; was_en = 1;
      end else if (scan_en) begin
        if (scan_data != prev) begin
          chk(scan_data == exp_pattern(steps_seen), "R2 step pattern", scan_data, exp_pattern(steps_seen));
          chk(hold == S, "R2 step length", hold, S);
          steps_seen++; prev = scan_data; hold = 1;
        end else hold++;
      end else if (was_en) begin
        chk(hold == S, "R2 last step length", hold, S);
        was_en = 0;
      end
    end
  end

  // read sequencer model and address scoreboard (R6, R7, R8)
  initial begin
    logic [31:0] a0;
    logic [31:0] ea;
    forever begin
      @(negedge clk);
      if (rst_n && rd_valid) begin
        a0 = rd_addr;
        for (int b = 0; b < bp; b++) begin
          @(negedge clk);
          chk(rd_valid && rd_addr == a0, "R7 held under back-pressure", rd_addr, a0);
        end
        if (exp_addr_q.size() == 0) begin
          chk(0, "R6 unexpected read", rd_addr, 0);
          ea = 0;
        end else begin
          ea = exp_addr_q.pop_front();
          chk(rd_addr == ea, "R6 read address", rd_addr, ea);
        end
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
        repeat (2) begin
          @(negedge clk);
          chk(!rd_valid, "R7 single outstanding", rd_valid, 0);
        end
        if (mode == 1 || mode == 3) ext_drv = ~ext_word[rd_idx];
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
        rd_idx++;
      end
    end
  end

  // result monitor: word scoreboard and grant gating (R3, R4, R8, R10)
  initial begin
    logic [35:0] ew;
    forever begin
      @(negedge clk);
      if (rst_n && !cfg_valid && mem_gnt) chk(0, "R10 grant before valid", mem_gnt, 0);
      if (rst_n && cfg_valid && !word_seen) begin
        word_seen = 1;
        ew = (exp_word_q.size() != 0) ? exp_word_q.pop_front() : 36'h0;
        chk(cfg_word == ew, "R3/R4/R8 loaded word", cfg_word, ew);
        chk(mem_gnt == 1'b1, "R10 grant with valid", mem_gnt, 1);
      end
    end
  end

  task automatic run_case(int m, int line, logic [35:0] w, int b);
    int nsteps;
    mode = m; tie_line = line; ext_word = w; bp = b;
    ext_drv = 1'b0; rd_idx = 0; force_en = 1'b0; mem_req = 1'b1;
    exp_addr_q.delete(); exp_word_q.delete();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    word_seen = 0;
    chk(!cfg_valid && !scan_en && !rd_valid && !mem_gnt, "R1 reset state",
        {cfg_valid, scan_en, rd_valid, mem_gnt}, 0);
    if (m == 0) begin
      nsteps = (line < 12) ? line : 12;
      exp_word_q.push_back(exp_preset(nsteps));
      nsteps = nsteps + 1;
    end else begin
      for (int i = 0; i < 36; i++)
        exp_addr_q.push_back(i == 0 ? 32'h7FFF_FF6C : 32'h7FFF_FF70 + 32'(4 * (i - 1)));
      exp_word_q.push_back(m == 2 ? 36'h0 : w);
      nsteps = 13;
    end
    rst_n = 1'b1;
    while (!cfg_valid) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(steps_seen == nsteps, "R2/R3/R5 probe steps", steps_seen, nsteps);
    chk(exp_addr_q.size() == 0, "R3/R6 read count", exp_addr_q.size(), 0);
    // pin activity after loading must not disturb the word (R9)
    force_en = 1'b1;
    for (int t = 0; t < 6; t++) begin
      force_val = t[0];
      @(negedge clk);
    end
    chk(cfg_valid && cfg_word == (m == 0 ? exp_preset(nsteps - 1) : (m == 2 ? 36'h0 : w)),
        "R9 word frozen", cfg_word, (m == 0 ? exp_preset(nsteps - 1) : (m == 2 ? 36'h0 : w)));
    chk(!scan_en && !rd_valid, "R9 bus quiet", {scan_en, rd_valid}, 0);
    mem_req = 1'b0;
    @(negedge clk);
    chk(!mem_gnt, "R10 no request no grant", mem_gnt, 0);
    mem_req = 1'b1;
    force_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    run_case(0, 0, '0, 0);
    run_case(0, 1, '0, 0);
    run_case(0, 7, '0, 0);
    run_case(0, 11, '0, 0);
    run_case(0, 31, '0, 0);            // R4 slowest preset
    run_case(1, 0, 36'h9A5C30F1E, 0);  // R8 external word
    run_case(1, 0, 36'h3C6E1B7D4, 3);  // R7 back-pressure
    run_case(2, 0, '0, 1);             // R8 all-high samples give zero
    run_case(3, 0, 36'hF0F00FF5A, 2);  // R5 low before scan blocks presets
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule